// File: doc/BRIEF.md
# SD card SPI-mode power-up sequencer

This block brings a freshly powered SD card into SPI mode and works out which generation it belongs to. When `start_i` arrives it asks the byte shifter for a run of idle bytes with the card deselected. It then drives a fixed series of commands through a separate command engine and decides what to do next from each one-byte R1 status or timeout that comes back.

The reply to the interface-condition check picks either the older-card branch or the newer-card branch. On both branches the block polls the card with the application-prefix/operating-condition pair until the card reports that it has left idle, giving up after a bounded number of attempts. Newer cards are also asked for their operating-condition register once. The sequence always ends by programming the block length. Only when that step succeeds does the block raise `ready_o` and switch the shifter to its fast clock.

A command stays presented on `cmd_idx_o`/`cmd_arg_o` with `cmd_valid_o` high until the engine pulses `cmd_done_i`. The engine returns the R1 byte in `cmd_r1_i`, or flags `cmd_timeout_i`, in that same cycle. Idle bytes follow the same scheme on `wake_req_o`/`wake_done_i`. CRC bytes and chip-select handling per command are the engine's concern.

Top module: `sd_init_seq`

## Requirements
- R1: After reset and before any start, card_type_o is 0, ready_o, fast_clk_o, done_o, busy_o, wake_req_o and cmd_valid_o are all low.
- R2: After start is accepted, exactly WAKE_BYTES (default 16) idle-byte requests complete before the first command, and no command is presented while idle bytes are requested.
- R3: The first command is index 0 with argument 0, and any reply other than 0x01 ends the sequence with type 0.
- R4: The second command is index 8 with argument 0x000001AA. A reply of 0x01 selects the newer-card branch, 0x05 selects the older-card branch, and any other value ends with type 0.
- R5: On both branches the block issues index 55 then index 41, both with argument 0, and repeats the pair until index 41 returns 0x00. The reply to index 55 is not examined.
- R6: The pair is attempted at most MAX_TRIES (default 5000) times. If the last allowed index-41 reply is still nonzero, the sequence ends with type 0, and success on exactly the last attempt is still accepted.
- R7: On the newer-card branch, index 58 with argument 0 is issued exactly once after index 41 returns 0x00. On the older-card branch it is never issued.
- R8: The final command is index 16 with argument BLOCK_LEN (default 512), and a nonzero reply ends with type 0.
- R9: On success, card_type_o reads 1 for the older branch and 2 for the newer branch, ready_o and done_o go high, and busy_o goes low. The code 0 means failure.
- R10: A timeout flagged on any command ends the sequence in the next cycle with done_o high and type 0.
- R11: fast_clk_o stays low until the block-length command succeeds. ready_o is never high with type 0, and a new start from the finished state clears all results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the sequence (accepted when not busy) |
| busy_o | output | 1 | Sequence in progress |
| wake_req_o | output | 1 | Request one idle byte with card deselected |
| wake_done_i | input | 1 | Idle byte finished |
| cmd_valid_o | output | 1 | Command presented to the engine |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_done_i | input | 1 | Engine finished the presented command |
| cmd_r1_i | input | 8 | R1 status byte, valid with cmd_done_i |
| cmd_timeout_i | input | 1 | No reply, valid with cmd_done_i |
| card_type_o | output | 2 | 0 fail, 1 older card, 2 newer card |
| ready_o | output | 1 | Card initialised and block length set |
| fast_clk_o | output | 1 | Select fast shifter clock |
| done_o | output | 1 | Sequence finished (either outcome) |

## Verification
The properties assume that the engine only pulses `cmd_done_i` while `cmd_valid_o` is high. They also assume that `wake_done_i` only pulses while `wake_req_o` is high, and that `start_i` is meaningful only when the block is idle or finished. The bench respects this by playing the engine itself. It answers a presented request only after seeing it for a cycle and drops each done pulse after one clock. It raises start only between runs, so every property sees a well-formed handshake.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

  typedef enum logic [1:0] {
    CT_FAIL = 2'd0,
    CT_V1   = 2'd1,
    CT_V2   = 2'd2
  } card_type_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_CMD,
    ST_FIN
  } seq_state_e;

  typedef enum logic [2:0] {
    SP_RESET,
    SP_IFCOND,
    SP_APP,
    SP_OPCOND,
    SP_OCR,
    SP_BLKLEN
  } step_e;

  typedef enum logic [2:0] {
    VD_ADVANCE,
    VD_FAIL,
    VD_BUSY,
    VD_SEL_V1,
    VD_SEL_V2
  } verdict_e;

  localparam logic [7:0] RSP_CLEAR       = 8'h00;
  localparam logic [7:0] RSP_IDLE        = 8'h01;
  localparam logic [7:0] RSP_IDLE_BADCMD = 8'h05;
  localparam logic [31:0] IFCOND_ARG     = 32'h0000_01AA;

  function automatic logic [5:0] step_cmd(step_e s);
    case (s)
      SP_RESET:  return 6'd0;
      SP_IFCOND: return 6'd8;
      SP_APP:    return 6'd55;
      SP_OPCOND: return 6'd41;
      SP_OCR:    return 6'd58;
      SP_BLKLEN: return 6'd16;
      default:   return 6'd0;
    endcase
  endfunction

  function automatic logic [31:0] step_arg(step_e s, logic [31:0] blk);
    case (s)
      SP_IFCOND: return IFCOND_ARG;
      SP_BLKLEN: return blk;
      default:   return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/sd_init_cnt.sv
module sd_init_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/sd_init_verdict.sv
module sd_init_verdict
  import sd_init_pkg::*;
(
  input  step_e      step_i,
  input  logic [7:0] r1_i,
  input  logic       timeout_i,
  output verdict_e   verdict_o
);
  always_comb begin
    verdict_o = VD_FAIL;
    if (!timeout_i) begin
      case (step_i)
        SP_RESET:  verdict_o = (r1_i == RSP_IDLE) ? VD_ADVANCE : VD_FAIL;
        SP_IFCOND: begin
          if (r1_i == RSP_IDLE)             verdict_o = VD_SEL_V2;
          else if (r1_i == RSP_IDLE_BADCMD) verdict_o = VD_SEL_V1;
          else                              verdict_o = VD_FAIL;
        end
        SP_APP:    verdict_o = VD_ADVANCE;            // reply not examined
        SP_OPCOND: verdict_o = (r1_i == RSP_CLEAR) ? VD_ADVANCE : VD_BUSY;
        SP_OCR:    verdict_o = VD_ADVANCE;
        SP_BLKLEN: verdict_o = (r1_i == RSP_CLEAR) ? VD_ADVANCE : VD_FAIL;
        default:   verdict_o = VD_FAIL;
      endcase
    end
  end
endmodule

// File: rtl/sd_init_fsm.sv
module sd_init_fsm
  import sd_init_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wake_done_i,
  input  logic       wake_last_i,
  input  logic       cmd_done_i,
  input  verdict_e   verdict_i,
  input  logic       try_last_i,
  output step_e      step_o,
  output logic       busy_o,
  output logic       wake_req_o,
  output logic       cmd_valid_o,
  output logic       wake_clr_o,
  output logic       wake_inc_o,
  output logic       try_clr_o,
  output logic       try_inc_o,
  output card_type_e type_o,
  output logic       ready_o,
  output logic       fast_o,
  output logic       done_o
);
  seq_state_e state_q;
  step_e      step_q;
  card_type_e ver_q, type_q;
  logic       ready_q, fast_q;
  logic       accept;

  assign accept = start_i && (state_q == ST_IDLE || state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= SP_RESET;
      ver_q   <= CT_FAIL;
      type_q  <= CT_FAIL;
      ready_q <= 1'b0;
      fast_q  <= 1'b0;
    end else if (accept) begin
      state_q <= ST_WAKE;
      step_q  <= SP_RESET;
      ver_q   <= CT_FAIL;
      type_q  <= CT_FAIL;
      ready_q <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_WAKE: if (wake_done_i && wake_last_i) state_q <= ST_CMD;
        ST_CMD: if (cmd_done_i) begin
          case (verdict_i)
            VD_SEL_V1: begin ver_q <= CT_V1; step_q <= SP_APP; end
            VD_SEL_V2: begin ver_q <= CT_V2; step_q <= SP_APP; end
            VD_BUSY: begin
              if (try_last_i) state_q <= ST_FIN;
              else            step_q  <= SP_APP;
            end
            VD_ADVANCE: begin
              case (step_q)
                SP_RESET:  step_q <= SP_IFCOND;
                SP_APP:    step_q <= SP_OPCOND;
                SP_OPCOND: step_q <= (ver_q == CT_V2) ? SP_OCR : SP_BLKLEN;
                SP_OCR:    step_q <= SP_BLKLEN;
                SP_BLKLEN: begin
                  state_q <= ST_FIN;
                  type_q  <= ver_q;
                  ready_q <= 1'b1;
                  fast_q  <= 1'b1;
                end
                default:   state_q <= ST_FIN;
              endcase
            end
            default: state_q <= ST_FIN;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign step_o      = step_q;
  assign busy_o      = (state_q == ST_WAKE) || (state_q == ST_CMD);
  assign wake_req_o  = (state_q == ST_WAKE);
  assign cmd_valid_o = (state_q == ST_CMD);
  assign wake_clr_o  = accept;
  assign try_clr_o   = accept;
  assign wake_inc_o  = (state_q == ST_WAKE) && wake_done_i;
  assign try_inc_o   = (state_q == ST_CMD) && cmd_done_i && (verdict_i == VD_BUSY);
  assign type_o      = type_q;
  assign ready_o     = ready_q;
  assign fast_o      = fast_q;
  assign done_o      = (state_q == ST_FIN);
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sd_init_pkg::*;
#(
  parameter int WAKE_BYTES = 16,
  parameter int MAX_TRIES  = 5000,
  parameter int BLOCK_LEN  = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        busy_o,
  output logic        wake_req_o,
  input  logic        wake_done_i,
  output logic        cmd_valid_o,
  output logic [5:0]  cmd_idx_o,
  output logic [31:0] cmd_arg_o,
  input  logic        cmd_done_i,
  input  logic [7:0]  cmd_r1_i,
  input  logic        cmd_timeout_i,
  output logic [1:0]  card_type_o,
  output logic        ready_o,
  output logic        fast_clk_o,
  output logic        done_o
);
  localparam logic [31:0] BLK_ARG = 32'(BLOCK_LEN);

  step_e      step;
  verdict_e   verdict;
  card_type_e ctype;
  logic wake_clr, wake_inc, wake_last;
  logic try_clr, try_inc, try_last;

  sd_init_cnt #(.LIMIT(WAKE_BYTES)) u_wake_cnt (
    .clk_i, .rst_ni, .clr_i(wake_clr), .inc_i(wake_inc), .last_o(wake_last)
  );

  sd_init_cnt #(.LIMIT(MAX_TRIES)) u_try_cnt (
    .clk_i, .rst_ni, .clr_i(try_clr), .inc_i(try_inc), .last_o(try_last)
  );

  sd_init_verdict u_verdict (
    .step_i(step), .r1_i(cmd_r1_i), .timeout_i(cmd_timeout_i), .verdict_o(verdict)
  );

  sd_init_fsm u_fsm (
    .clk_i, .rst_ni, .start_i,
    .wake_done_i, .wake_last_i(wake_last),
    .cmd_done_i, .verdict_i(verdict), .try_last_i(try_last),
    .step_o(step), .busy_o, .wake_req_o, .cmd_valid_o,
    .wake_clr_o(wake_clr), .wake_inc_o(wake_inc),
    .try_clr_o(try_clr), .try_inc_o(try_inc),
    .type_o(ctype), .ready_o, .fast_o(fast_clk_o), .done_o
  );

  assign cmd_idx_o   = step_cmd(step);
  assign cmd_arg_o   = step_arg(step, BLK_ARG);
  assign card_type_o = ctype;
endmodule

// File: rtl/sd_init_chk.sv
module sd_init_chk #(
  parameter int WAKE_BYTES = 16,
  parameter int MAX_TRIES  = 5000,
  parameter int BLOCK_LEN  = 512
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        wake_req_o,
  input logic        wake_done_i,
  input logic        cmd_valid_o,
  input logic [5:0]  cmd_idx_o,
  input logic [31:0] cmd_arg_o,
  input logic        cmd_done_i,
  input logic [7:0]  cmd_r1_i,
  input logic        cmd_timeout_i,
  input logic [1:0]  card_type_o,
  input logic        ready_o,
  input logic        fast_clk_o,
  input logic        done_o
);
  logic [31:0] wake_seen, op_seen;
  logic        restart;

  assign restart = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_seen <= '0;
      op_seen   <= '0;
    end else if (restart) begin
      wake_seen <= '0;
      op_seen   <= '0;
    end else begin
      if (wake_req_o && wake_done_i) wake_seen <= wake_seen + 1;
      if (cmd_valid_o && cmd_done_i && cmd_idx_o == 6'd41 && !cmd_timeout_i)
        op_seen <= op_seen + 1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wake_req_o && !cmd_valid_o);

  p_wake_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_req_o && cmd_valid_o));

  p_wake_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_idx_o == 6'd0 |-> wake_seen == WAKE_BYTES);

  p_bad_reset_reply_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_done_i && cmd_idx_o == 6'd0 && !cmd_timeout_i && cmd_r1_i != 8'h01
    |=> done_o && card_type_o == 2'd0);

  p_cmd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_idx_o) && $stable(cmd_arg_o));

  p_retry_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_seen <= MAX_TRIES);

  p_blklen_arg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_idx_o == 6'd16 |-> cmd_arg_o == 32'(BLOCK_LEN));

  p_timeout_fail_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_done_i && cmd_timeout_i |=> done_o && card_type_o == 2'd0 && !ready_o);

  p_ready_type_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> card_type_o != 2'd0 && done_o);

  p_fast_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_clk_o |-> ready_o);
endmodule

bind sd_init_seq sd_init_chk #(
  .WAKE_BYTES(WAKE_BYTES), .MAX_TRIES(MAX_TRIES), .BLOCK_LEN(BLOCK_LEN)
) u_chk (.*);

// File: tb/sd_init_seq_bench.sv
module sd_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE  = 16;
  localparam int TRIES = 5000;
  localparam int BLK   = 512;
  localparam int RUN_LIMIT = 60000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic wake_done = 1'b0, cmd_done = 1'b0, cmd_to = 1'b0;
  logic [7:0] cmd_r1 = 8'hFF;
  logic busy, wake_req, cmd_valid, ready, fast, done;
  logic [5:0] cmd_idx;
  logic [31:0] cmd_arg;
  logic [1:0] ctype;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_init_seq u_sd_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy),
    .wake_req_o(wake_req), .wake_done_i(wake_done),
    .cmd_valid_o(cmd_valid), .cmd_idx_o(cmd_idx), .cmd_arg_o(cmd_arg),
    .cmd_done_i(cmd_done), .cmd_r1_i(cmd_r1), .cmd_timeout_i(cmd_to),
    .card_type_o(ctype), .ready_o(ready), .fast_clk_o(fast), .done_o(done)
  );

  int checks = 0, fails = 0;
  // card scenario
  int sc_r0, sc_r8, sc_busy, sc_r16, sc_to_idx, card_41;
  // reference model
  int m_step, m_tries, m_ver, m_wake, n58, n41;
  int e_type; bit e_ready, e_fast, e_done, e_busy;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int idx);
    case (idx)
      0:       return "R3";
      8:       return "R4";
      55, 41:  return "R5";
      58:      return "R7";
      16:      return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic card_reply(input int idx, output logic [7:0] r, output logic to);
    to = (idx == sc_to_idx);
    case (idx)
      0:  r = sc_r0[7:0];
      8:  r = sc_r8[7:0];
      41: begin
        if (sc_busy < 0 || card_41 < sc_busy) begin card_41++; r = 8'h01; end
        else r = 8'h00;
      end
      16: r = sc_r16[7:0];
      55: r = 8'h01;
      default: r = 8'h00;
    endcase
  endtask

  task automatic m_fail();
    e_done = 1; e_busy = 0; e_type = 0; e_ready = 0; e_fast = 0; m_step = -1;
  endtask

  task automatic model_cmd(input int idx, input logic [7:0] r, input logic to);
    if (idx == 41) n41++;
    if (idx == 58) n58++;
    if (to) begin m_fail(); return; end
    case (idx)
      0:  if (r == 8'h01) m_step = 8; else m_fail();
      8:  if (r == 8'h01) begin m_ver = 2; m_step = 55; end
          else if (r == 8'h05) begin m_ver = 1; m_step = 55; end
          else m_fail();
      55: m_step = 41;
      41: if (r == 8'h00) m_step = (m_ver == 2) ? 58 : 16;
          else begin
            m_tries++;
            if (m_tries >= TRIES) m_fail(); else m_step = 55;
          end
      58: m_step = 16;
      16: if (r == 8'h00) begin
            e_type = m_ver; e_ready = 1; e_fast = 1; e_done = 1; e_busy = 0; m_step = -1;
          end else m_fail();
      default: m_fail();
    endcase
  endtask

  task automatic compare();
    chk(ctype == 2'(e_type), "R9", "card_type", ctype, e_type);
    chk(ready == e_ready, "R11", "ready", ready, e_ready);
    chk(fast == e_fast, "R11", "fast_clk", fast, e_fast);
    chk(done == e_done, "R10", "done", done, e_done);
    chk(busy == e_busy, "R9", "busy", busy, e_busy);
  endtask

  task automatic run_case(input int r0, input int r8, input int bz,
                          input int r16, input int to_idx);
    int cyc = 0;
    bit wait_c = 0, pw = 0, pc = 0;
    int pidx = 0;
    logic [7:0] pr;
    logic pto;
    sc_r0 = r0; sc_r8 = r8; sc_busy = bz; sc_r16 = r16; sc_to_idx = to_idx;
    card_41 = 0; m_tries = 0; m_ver = 0; n58 = 0; n41 = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    e_busy = 1; e_type = 0; e_ready = 0; e_fast = 0; e_done = 0; m_wake = 0; m_step = -1;
    forever begin
      if (pw) begin
        wake_done = 1'b0; pw = 0; m_wake++;
        if (m_wake == WAKE) m_step = 0;
      end
      if (pc) begin cmd_done = 1'b0; pc = 0; model_cmd(pidx, pr, pto); end
      compare();
      if (e_done) break;
      if (cyc > RUN_LIMIT) begin
        chk(1'b0, "R10", "watchdog expired", cyc, RUN_LIMIT);
        break;
      end
      if (wake_req) begin
        chk(!cmd_valid && m_wake < WAKE, "R2", "idle byte request", m_wake, WAKE - 1);
        wake_done = 1'b1; pw = 1;
      end else if (cmd_valid) begin
        if (!wait_c) wait_c = 1;
        else begin
          wait_c = 0;
          chk(int'(cmd_idx) == m_step, tag_of(m_step), "cmd index", cmd_idx, m_step);
          if (m_step == 0) chk(m_wake == WAKE, "R2", "idle bytes before first cmd", m_wake, WAKE);
          chk(cmd_arg == (m_step == 8 ? 32'h1AA : m_step == 16 ? 32'(BLK) : 32'd0),
              tag_of(m_step), "cmd arg", cmd_arg, m_step);
          pidx = int'(cmd_idx);
          card_reply(pidx, pr, pto);
          cmd_r1 = pr; cmd_to = pto; cmd_done = 1'b1; pc = 1;
        end
      end
      @(negedge clk); cyc++;
    end
    @(negedge clk);
    cmd_to = 1'b0; cmd_r1 = 8'hFF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ctype == 2'd0 && !ready && !fast && !done && !busy, "R1", "outputs in reset",
        {ctype, ready, fast, done, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wake_req && !cmd_valid && !busy && ctype == 2'd0, "R1", "idle after reset",
        {wake_req, cmd_valid, busy}, 0);

    // newer card, three busy polls (R4 R5 R7 R9)
    run_case(1, 1, 3, 0, -1);
    chk(ctype == 2'd2 && ready && fast, "R9", "newer card result", ctype, 2);
    chk(n58 == 1, "R7", "ocr read count on newer card", n58, 1);
    chk(n41 == 4, "R5", "poll count", n41, 4);

    // older card, ready at first poll
    run_case(1, 5, 0, 0, -1);
    chk(ctype == 2'd1 && ready && fast, "R9", "older card result", ctype, 1);
    chk(n58 == 0, "R7", "ocr read skipped on older card", n58, 0);

    // bad reset reply
    run_case(0, 1, 0, 0, -1);
    chk(ctype == 2'd0 && !ready && done, "R3", "reset reply 0x00 fails", ctype, 0);

    // bad interface-check reply
    run_case(1, 9, 0, 0, -1);
    chk(ctype == 2'd0 && !ready, "R4", "ifcond reply 0x09 fails", ctype, 0);

    // block length rejected
    run_case(1, 1, 0, 8'h40, -1);
    chk(ctype == 2'd0 && !fast && !ready, "R8", "blklen reject keeps slow clock", fast, 0);

    // timeouts
    run_case(1, 5, 2, 0, 55);
    chk(ctype == 2'd0 && done, "R10", "timeout on app prefix", ctype, 0);
    run_case(1, 1, 0, 0, 16);
    chk(ctype == 2'd0 && !fast, "R10", "timeout on blklen", fast, 0);

    // retry exhaustion
    run_case(1, 1, -1, 0, -1);
    chk(n41 == TRIES && ctype == 2'd0, "R6", "poll attempts before giving up", n41, TRIES);

    // success on the very last allowed attempt, also a restart from finished
    run_case(1, 5, TRIES - 1, 0, -1);
    chk(n41 == TRIES && ctype == 2'd1 && ready, "R6", "success on last attempt", n41, TRIES);
    chk(fast, "R11", "fast clock after late success", fast, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule